// File: doc/BRIEF.md
# SHA-256 Chaining Value Accumulator

This block keeps the eight 32-bit chaining words of a SHA-256 hash between message blocks. It sits next to the compression round unit. At the end of every 512-bit block it folds the round results into the stored words. It does not use eight parallel adders. The words are held in two four-word shifting chains, one for the A side (DM0 to DM3) and one for the E side (DM4 to DM7). Each chain has a single adder. The round unit presents its A and E taps over four update beats. On the first three beats the tap is added to the word at the head of the chain. On the fourth beat the tap is the finished DM0 or DM4 value, already summed in the round unit's own A and E registers, and it is written as is.

The same two chains are linked end to end into an eight-word circular buffer. This buffer serves two purposes:
- Loading an arbitrary initialization vector, for keyed hashing or for resuming a fragmented message. Each word enters a single register and travels around the ring.
- Reading the digest out one word per cycle from a fixed position, so no wide output multiplexer is needed.

After a full rotation the buffer holds its original contents. Reset and a one-cycle strobe both restore the standard SHA-256 initial value without using the shift path.

Top module: `sha_digest_acc`

## Requirements
- R1: After reset the stored words DM0..DM7 are 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19.
- R2: A pulse on ivDefault in an idle cycle restores those eight words in one cycle. Idle means no readout running, no IV load part done and no update part done.
- R3: An IV load is accepted when idle. It consists of exactly 8 cycles with ivValid high, and idle cycles between them are allowed. The k-th accepted ivData word (k = 0..7) becomes DMk.
- R4: An update is four updValid beats. Beats 0, 1 and 2 add aTap to DM3, DM2 and DM1 respectively, and add eTap to DM7, DM6 and DM5, all modulo 2^32. Beat 3 writes aTap into DM0 and eTap into DM4 with no addition.
- R5: rdStart in an idle cycle starts a readout. From the next cycle on, rdValid is high for exactly 8 cycles, and rdData carries DM0 through DM7 in order, one word per cycle.
- R6: A readout leaves the stored words unchanged, so a second readout returns the same eight words.
- R7: While an IV load is part done, updValid, rdStart and ivDefault are ignored. In an idle cycle, ivValid takes priority over the other requests, and those requests are then ignored.
- R8: While a readout runs, updValid, ivValid and ivDefault are ignored.
- R9: While an update is part done (1 to 3 beats taken), rdStart, ivValid and ivDefault are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, loads the default IV |
| ivDefault | input | 1 | Restore the standard initial value |
| ivValid | input | 1 | IV word strobe |
| ivData | input | 32 | IV word |
| updValid | input | 1 | Update beat strobe |
| aTap | input | 32 | A-side value from the round unit |
| eTap | input | 32 | E-side value from the round unit |
| rdStart | input | 1 | Start an 8-beat digest readout |
| rdValid | output | 1 | Readout beat valid |
| rdData | output | 32 | Readout word |

## Verification
Every strobe takes effect at the clock edge that samples it. An IV word, a default restore or an update beat is therefore visible only through a later readout, and the bench compares that readout against its own model of the eight words. An accepted rdStart raises rdValid one cycle later, carrying DM0. Each further cycle moves to the next word, and rdValid falls after the eighth beat. The bench drives inputs and samples rdValid and rdData on falling edges, so beat k is compared in the k-th falling edge after the start edge. Requests that must be ignored are issued in the middle of loads, updates and readouts. Their absence of effect is then confirmed through the next full readout and by rdValid staying low.

// File: rtl/sha_digest_pkg.sv
package sha_digest_pkg;

  typedef struct packed {
    logic shiftIv;
    logic shiftRd;
    logic updBeat;
    logic updLast;
    logic loadDefault;
  } dig_ctl_t;

  function automatic logic [31:0] defIv(input logic [2:0] idx);
    case (idx)
      3'd0: defIv = 32'h6a09e667;
      3'd1: defIv = 32'hbb67ae85;
      3'd2: defIv = 32'h3c6ef372;
      3'd3: defIv = 32'ha54ff53a;
      3'd4: defIv = 32'h510e527f;
      3'd5: defIv = 32'h9b05688c;
      3'd6: defIv = 32'h1f83d9ab;
      default: defIv = 32'h5be0cd19;
    endcase
  endfunction

endpackage

// File: rtl/sha_digest_ctrl.sv
module sha_digest_ctrl
  import sha_digest_pkg::*;
#(
  parameter int CHAIN_LEN = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ivDefault,
  input  logic     ivValid,
  input  logic     updValid,
  input  logic     rdStart,
  output dig_ctl_t ctl,
  output logic     rdValid
);
  localparam int RING_LEN = 2 * CHAIN_LEN;
  localparam int RW = $clog2(RING_LEN);
  localparam int UW = $clog2(CHAIN_LEN);

  logic [RW-1:0] ivCnt;
  logic [RW-1:0] rdCnt;
  logic [UW-1:0] updCnt;
  logic          reading;
  logic          idle;
  logic          startRd;

  assign idle = !reading && (ivCnt == '0) && (updCnt == '0);

  always_comb begin
    ctl             = '0;
    ctl.shiftIv     = ivValid && ((ivCnt != '0) || idle);
    ctl.loadDefault = ivDefault && idle && !ivValid;
    ctl.shiftRd     = reading;
    ctl.updBeat     = updValid && !reading && (ivCnt == '0)
                      && !ctl.shiftIv && !ctl.loadDefault;
    ctl.updLast     = ctl.updBeat && (updCnt == UW'(CHAIN_LEN - 1));
  end

  assign startRd = rdStart && idle && !ivValid && !ivDefault && !updValid;
  assign rdValid = reading;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivCnt   <= '0;
      rdCnt   <= '0;
      updCnt  <= '0;
      reading <= 1'b0;
    end else begin
      if (ctl.shiftIv) ivCnt <= (ivCnt == RW'(RING_LEN - 1)) ? '0 : ivCnt + 1'b1;
      if (ctl.updBeat) updCnt <= ctl.updLast ? '0 : updCnt + 1'b1;
      if (startRd) begin
        reading <= 1'b1;
        rdCnt   <= '0;
      end else if (reading) begin
        rdCnt <= rdCnt + 1'b1;
        if (rdCnt == RW'(RING_LEN - 1)) reading <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sha_digest_dpath.sv
module sha_digest_dpath
  import sha_digest_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CHAIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dig_ctl_t          ctl,
  input  logic [WORD_W-1:0] ivData,
  input  logic [WORD_W-1:0] aTap,
  input  logic [WORD_W-1:0] eTap,
  output logic [WORD_W-1:0] rdData
);
  localparam int LAST = CHAIN_LEN - 1;

  // aCh[0] holds DM(LAST) at rest, aCh[LAST] holds DM0; eCh likewise for DM4..DM7
  logic [WORD_W-1:0] aCh [CHAIN_LEN];
  logic [WORD_W-1:0] eCh [CHAIN_LEN];
  logic [WORD_W-1:0] aSum;
  logic [WORD_W-1:0] eSum;

  // old word is gated to zero on the last beat: fresh DM0/DM4 arrive pre-summed
  assign aSum = aTap + (ctl.updLast ? '0 : aCh[0]);
  assign eSum = eTap + (ctl.updLast ? '0 : eCh[0]);
  assign rdData = aCh[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CHAIN_LEN; i++) begin
        aCh[i] <= WORD_W'(defIv(3'(LAST - i)));
        eCh[i] <= WORD_W'(defIv(3'(CHAIN_LEN + LAST - i)));
      end
    end else if (ctl.loadDefault) begin
      for (int i = 0; i < CHAIN_LEN; i++) begin
        aCh[i] <= WORD_W'(defIv(3'(LAST - i)));
        eCh[i] <= WORD_W'(defIv(3'(CHAIN_LEN + LAST - i)));
      end
    end else if (ctl.shiftIv || ctl.shiftRd) begin
      // circular buffer: eCh[0] -> ... -> eCh[LAST] -> aCh[0] -> ... -> aCh[LAST] -> eCh[0]
      for (int i = 1; i < CHAIN_LEN; i++) begin
        aCh[i] <= aCh[i-1];
        eCh[i] <= eCh[i-1];
      end
      aCh[0] <= eCh[LAST];
      eCh[0] <= ctl.shiftIv ? ivData : aCh[LAST];
    end else if (ctl.updBeat) begin
      for (int i = 0; i < LAST; i++) begin
        aCh[i] <= aCh[i+1];
        eCh[i] <= eCh[i+1];
      end
      aCh[LAST] <= aSum;
      eCh[LAST] <= eSum;
    end
  end

endmodule

// File: rtl/sha_digest_acc.sv
module sha_digest_acc
  import sha_digest_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ivDefault,
  input  logic              ivValid,
  input  logic [WORD_W-1:0] ivData,
  input  logic              updValid,
  input  logic [WORD_W-1:0] aTap,
  input  logic [WORD_W-1:0] eTap,
  input  logic              rdStart,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  localparam int CHAIN_LEN = 4;

  dig_ctl_t ctl;

  sha_digest_ctrl #(.CHAIN_LEN(CHAIN_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .ivDefault(ivDefault), .ivValid(ivValid),
    .updValid(updValid), .rdStart(rdStart), .ctl(ctl), .rdValid(rdValid)
  );

  sha_digest_dpath #(.WORD_W(WORD_W), .CHAIN_LEN(CHAIN_LEN)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ivData(ivData),
    .aTap(aTap), .eTap(eTap), .rdData(rdData)
  );

endmodule

// File: rtl/sha_digest_chk.sv
module sha_digest_chk
  import sha_digest_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     rdStart,
  input logic     rdValid,
  input dig_ctl_t ctl
);
  logic [3:0] runCnt;
  logic [2:0] ivSeen;
  logic [1:0] updSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      ivSeen  <= '0;
      updSeen <= '0;
    end else begin
      runCnt <= rdValid ? runCnt + 1'b1 : '0;
      if (ctl.shiftIv) ivSeen <= ivSeen + 1'b1;
      if (ctl.updBeat) updSeen <= updSeen + 1'b1;
    end
  end

  a_r5_rd_len: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (runCnt < 4'd8));

  a_r5_rd_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(rdStart));

  a_r7_no_rd_in_iv: assert property (@(posedge clk) disable iff (!rstN)
    (ivSeen != 3'd0) |-> (!rdValid && !ctl.updBeat && !ctl.loadDefault));

  a_r8_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftIv, ctl.shiftRd, ctl.updBeat, ctl.loadDefault}));

  a_r4_last_beat: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updBeat |-> (ctl.updLast == (updSeen == 2'd3)));

  a_r9_no_rd_mid_upd: assert property (@(posedge clk) disable iff (!rstN)
    (updSeen != 2'd0) |=> !$rose(rdValid));

endmodule

bind sha_digest_acc sha_digest_chk i_chk (
  .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdValid(rdValid), .ctl(ctl)
);

// File: tb/test_sha_digest_acc.sv
module test_sha_digest_acc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ivDefault = 1'b0, ivValid = 1'b0, updValid = 1'b0, rdStart = 1'b0;
  logic [31:0] ivData = '0, aTap = '0, eTap = '0;
  logic        rdValid;
  logic [31:0] rdData;

  int nChk = 0, nBad = 0, cyc = 0;
  logic [31:0] expW [8];
  logic [31:0] seedVal;

  always #5 clk = ~clk;

  sha_digest_acc i_sha_digest_acc (
    .clk(clk), .rstN(rstN), .ivDefault(ivDefault), .ivValid(ivValid), .ivData(ivData),
    .updValid(updValid), .aTap(aTap), .eTap(eTap), .rdStart(rdStart),
    .rdValid(rdValid), .rdData(rdData)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nBad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  function automatic logic [31:0] stdIv(int i);
    logic [31:0] t [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                           32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    return t[i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    ivDefault = 0; ivValid = 0; updValid = 0; rdStart = 0;
  endtask

  // full readout; optional noise requests that must be ignored (R8)
  task automatic readAll(string req, bit noise);
    rdStart = 1;
    @(negedge clk);
    rdStart = 0;
    for (int k = 0; k < 8; k++) begin
      chk({req, " rdValid"}, {31'b0, rdValid}, 32'd1);
      chk({req, " word"}, rdData, expW[k]);
      if (noise) begin
        updValid = 1; aTap = $urandom; eTap = $urandom;
        ivValid = $urandom_range(0, 1); ivData = $urandom;
        ivDefault = $urandom_range(0, 1);
      end
      @(negedge clk);
    end
    clearIn();
    chk({req, " rdValid end"}, {31'b0, rdValid}, 32'd0);
  endtask

  // R3 load; noise in gaps exercises R7
  task automatic loadIv(bit noise);
    for (int k = 0; k < 8; k++) begin
      if (k > 0 && $urandom_range(0, 2) == 0) begin
        if (noise) begin
          updValid = 1; aTap = $urandom; rdStart = 1; ivDefault = 1;
        end
        @(negedge clk);
        clearIn();
        chk("R7 no readout mid-load", {31'b0, rdValid}, 32'd0);
      end
      ivValid = 1; ivData = $urandom;
      if (noise && k == 0) begin updValid = 1; rdStart = 1; end
      expW[k] = ivData;
      @(negedge clk);
      clearIn();
    end
  endtask

  // R4 update; noise in gaps exercises R9
  task automatic doUpdate(bit noise, logic [31:0] fixA, logic [31:0] fixE, bit useFix);
    for (int b = 0; b < 4; b++) begin
      logic [31:0] a, e;
      if (b > 0 && noise) begin
        rdStart = 1; ivValid = 1; ivData = $urandom; ivDefault = 1;
        @(negedge clk);
        clearIn();
        chk("R9 no readout mid-update", {31'b0, rdValid}, 32'd0);
      end
      a = useFix ? fixA : $urandom;
      e = useFix ? fixE : $urandom;
      updValid = 1; aTap = a; eTap = e;
      if (b < 3) begin
        expW[3-b] = expW[3-b] + a;
        expW[7-b] = expW[7-b] + e;
      end else begin
        expW[0] = a;
        expW[4] = e;
      end
      @(negedge clk);
      clearIn();
    end
  endtask

  initial begin
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < 8; i++) expW[i] = stdIv(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle after reset", {31'b0, rdValid}, 32'd0);
    readAll("R1", 0);

    // directed: wrap-around addition
    doUpdate(0, 32'hffffffff, 32'h80000001, 1);
    readAll("R4 wrap", 0);
    readAll("R6 repeat", 0);

    for (int it = 0; it < 6; it++) begin
      loadIv(it[0]);
      readAll("R3", it == 2);
      doUpdate(it[1], '0, '0, 0);
      readAll("R4", 0);
      readAll("R6", it[0]);
    end

    // R8: noise during readout already applied; confirm state survives
    readAll("R8", 0);

    ivDefault = 1;
    @(negedge clk);
    clearIn();
    for (int i = 0; i < 8; i++) expW[i] = stdIv(i);
    readAll("R2", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule